// File: doc/BRIEF.md
# Triple Buffer Frame Controller

This block decides which of three frame-sized regions of external memory a slow video writer fills and which one a fixed-rate display reader scans out. The writer produces progressive frames at half the display rate (30 against 60 frames per second), so the reader often needs a frame before a new one exists. In that case it is handed the frame it already showed. No finished frame is ever thrown away. When every region is occupied, the writer is made to wait.

The writer holds a request until it sees a one-cycle grant, then fills the region at the granted base address and pulses done when the frame is complete. The reader pulses start at the top of each output frame and then scans from the reported base address while the valid flag is high. Each frame is 1024×768 pixels at three bytes per pixel (8-bit R, G and B side by side). The three regions are packed back to back from the storage base address 0x10000000. The pixel path, the memory masters and the bus arbitration lie outside this block.

Top module: `tbfc_frame_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `wr_grant_o` and `rd_valid_o` are 0, and both base outputs equal the storage base 0x10000000.
- R2: Region k has base address 0x10000000 + k × 2359296 (1024×768×3). This gives 0x10000000, 0x10240000 and 0x10480000 for k = 0, 1, 2.
- R3: A grant always names a free region: one that is not being filled, not being scanned and not holding an unread frame. The lowest-numbered free region is chosen, so the first grant after reset is region 0.
- R4: While `wr_req_i` is high and no region is free, no grant is given. The grant comes one cycle after a region is freed.
- R5: `wr_grant_o` is a one-cycle pulse. It appears in the cycle after a cycle in which `wr_req_i` was high, no frame was being filled and a region was free.
- R6: `wr_done_i` turns the region being filled into an unread frame. A `wr_done_i` that arrives while no frame is being filled has no effect.
- R7: At `rd_start_i`, if unread frames exist, the reader moves to the oldest one. The region it was scanning becomes free.
- R8: At `rd_start_i` with no unread frame, the reader keeps its current region, so the last shown frame is repeated.
- R9: `rd_valid_o` stays 0 until a `rd_start_i` finds a completed frame. After that it stays 1 until reset.
- R10: `rd_base_o` changes only in the cycle after a `rd_start_i`, never while a frame is being scanned.
- R11: A frame whose `wr_done_i` arrives in the same cycle as `rd_start_i` can be picked up by that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_req_i | input | 1 | Writer asks for a region for its next frame |
| wr_done_i | input | 1 | Writer finished the frame it was granted |
| wr_grant_o | output | 1 | One-cycle grant; `wr_base_o` is valid with it |
| wr_base_o | output | 32 | Base byte address of the region to fill |
| rd_start_i | input | 1 | Reader begins an output frame |
| rd_valid_o | output | 1 | A completed frame is available for scan-out |
| rd_base_o | output | 32 | Base byte address of the region to scan |

## Verification
The bench builds the block with its default parameters: three regions of 1024×768×3 bytes starting at 0x10000000. With only three regions, the full case comes up after just three writer frames. That is the case where one region is being scanned and two hold unread frames, and it lets the bench check the writer stall, the release after a read, and the oldest-first order. The actual frame size shows up in the exact base addresses that are checked. It also makes the bench check the multiply-and-offset address mapping, not just the region indices.

// File: rtl/tbfc_pkg.sv
package tbfc_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_FILL  = 2'd1,
        SLOT_READY = 2'd2,
        SLOT_SCAN  = 2'd3
    } slot_state_e;
endpackage

// File: rtl/tbfc_free_pick.sv
module tbfc_free_pick #(
    parameter int NUM_SLOTS = 3,
    parameter int SLOT_W    = 2
) (
    input  logic [NUM_SLOTS-1:0] free_i,
    output logic                 found_o,
    output logic [SLOT_W-1:0]    idx_o
);
    // Lowest index wins: scan downward so the last hit is the smallest.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (free_i[i]) begin
                found_o = 1'b1;
                idx_o   = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/tbfc_ready_queue.sv
module tbfc_ready_queue #(
    parameter int NUM_SLOTS = 3,
    parameter int SLOT_W    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [SLOT_W-1:0] push_idx_i,
    input  logic              pop_i,
    output logic              avail_o,
    output logic [SLOT_W-1:0] head_o
);
    localparam int CNT_W = $clog2(NUM_SLOTS + 1);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][SLOT_W-1:0] ent;
        logic [CNT_W-1:0]                 cnt;
    } rq_t;

    rq_t q_q, q_d;

    // A push in the same cycle is visible to a pop (bypass).
    assign avail_o = (q_q.cnt != '0) || push_i;
    assign head_o  = (q_q.cnt != '0) ? q_q.ent[0] : push_idx_i;

    always_comb begin
        int shift;
        int src;
        q_d   = q_q;
        shift = (pop_i && avail_o) ? 1 : 0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            src = k + shift;
            if (src < int'(q_q.cnt)) begin
                q_d.ent[k] = q_q.ent[src];
            end else if (src == int'(q_q.cnt) && push_i) begin
                q_d.ent[k] = push_idx_i;
            end else begin
                q_d.ent[k] = '0;
            end
        end
        q_d.cnt = CNT_W'(int'(q_q.cnt) + (push_i ? 1 : 0) - shift);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    // R4
    queue_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> (int'(q_q.cnt) < NUM_SLOTS) || pop_i);
endmodule

// File: rtl/tbfc_frame_ctrl.sv
module tbfc_frame_ctrl #(
    parameter int              ADDR_W          = 32,
    parameter logic [ADDR_W-1:0] REGION_BASE   = 32'h1000_0000,
    parameter int              H_ACTIVE        = 1024,
    parameter int              V_ACTIVE        = 768,
    parameter int              BYTES_PER_PIXEL = 3,
    parameter int              NUM_SLOTS       = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_req_i,
    input  logic              wr_done_i,
    output logic              wr_grant_o,
    output logic [ADDR_W-1:0] wr_base_o,
    input  logic              rd_start_i,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_base_o
);
    import tbfc_pkg::*;

    localparam int unsigned FRAME_BYTES = H_ACTIVE * V_ACTIVE * BYTES_PER_PIXEL;
    localparam int          SLOT_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef struct packed {
        slot_state_e [NUM_SLOTS-1:0] st;
        logic                        wr_active;
        logic [SLOT_W-1:0]           wr_slot;
        logic [SLOT_W-1:0]           rd_slot;
        logic                        rd_valid;
        logic                        grant;
        logic [ADDR_W-1:0]           wr_base;
        logic [ADDR_W-1:0]           rd_base;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] slot_base(input logic [SLOT_W-1:0] idx);
        return REGION_BASE + ADDR_W'(idx) * ADDR_W'(FRAME_BYTES);
    endfunction

    ctrl_t q_q, q_d;

    logic [NUM_SLOTS-1:0] free_mask;
    logic [NUM_SLOTS-1:0] fill_mask;
    logic [NUM_SLOTS-1:0] scan_mask;
    logic                 free_found;
    logic [SLOT_W-1:0]    free_idx;
    logic                 push;
    logic                 pop;
    logic                 ready_avail;
    logic [SLOT_W-1:0]    ready_head;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
        assign free_mask[g] = (q_q.st[g] == SLOT_FREE);
        assign fill_mask[g] = (q_q.st[g] == SLOT_FILL);
        assign scan_mask[g] = (q_q.st[g] == SLOT_SCAN);
    end

    tbfc_free_pick #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) i_pick (
        .free_i  (free_mask),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    assign push = wr_done_i && q_q.wr_active;

    tbfc_ready_queue #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) i_ready (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (push),
        .push_idx_i (q_q.wr_slot),
        .pop_i      (pop),
        .avail_o    (ready_avail),
        .head_o     (ready_head)
    );

    assign pop = rd_start_i && ready_avail;

    always_comb begin
        q_d       = q_q;
        q_d.grant = 1'b0;
        // Writer completion first, so a same-cycle reader start can take it.
        if (push) begin
            q_d.st[q_q.wr_slot] = SLOT_READY;
            q_d.wr_active       = 1'b0;
        end
        if (pop) begin
            if (q_q.rd_valid) begin
                q_d.st[q_q.rd_slot] = SLOT_FREE;
            end
            q_d.st[ready_head] = SLOT_SCAN;
            q_d.rd_slot        = ready_head;
            q_d.rd_valid       = 1'b1;
            q_d.rd_base        = slot_base(ready_head);
        end
        if (wr_req_i && !q_q.wr_active && free_found) begin
            q_d.st[free_idx] = SLOT_FILL;
            q_d.wr_active    = 1'b1;
            q_d.wr_slot      = free_idx;
            q_d.wr_base      = slot_base(free_idx);
            q_d.grant        = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q_q         <= '0;
            q_q.wr_base <= REGION_BASE;
            q_q.rd_base <= REGION_BASE;
        end else begin
            q_q <= q_d;
        end
    end

    assign wr_grant_o = q_q.grant;
    assign wr_base_o  = q_q.wr_base;
    assign rd_valid_o = q_q.rd_valid;
    assign rd_base_o  = q_q.rd_base;

    // R5
    grant_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_grant_o |=> !wr_grant_o);

    // R3
    grant_not_scanned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_grant_o |-> !(rd_valid_o && (rd_base_o == wr_base_o)));

    // R9
    valid_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_valid_o) |-> $past(rd_start_i));

    // R9
    valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |=> rd_valid_o);

    // R10
    base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rd_start_i) |-> $stable(rd_base_o));

    // R6
    single_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(fill_mask) <= 1 && $countones(scan_mask) <= 1);
endmodule

// File: tb/test_tbfc_frame_ctrl.sv
module test_tbfc_frame_ctrl;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam int          FB   = 1024 * 768 * 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        done = 1'b0;
    logic        rds = 1'b0;
    logic        grant;
    logic        valid;
    logic [31:0] wbase;
    logic [31:0] rbase;

    always #2 clk = ~clk;

    tbfc_frame_ctrl i_tbfc_frame_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_req_i   (req),
        .wr_done_i  (done),
        .wr_grant_o (grant),
        .wr_base_o  (wbase),
        .rd_start_i (rds),
        .rd_valid_o (valid),
        .rd_base_o  (rbase)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Behavioural reference: who writes, who reads, queue of unread frames.
    int          m_wr = -1;
    int          m_rd = -1;
    int          rq[$];
    bit          e_grant;
    bit          e_valid;
    logic [31:0] e_wbase;
    logic [31:0] e_rbase;

    function automatic logic [31:0] addr(int s);
        return BASE + 32'(s * FB);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic model_tick();
        if (!rst_n) begin
            m_wr = -1; m_rd = -1; rq.delete();
            e_grant = 0; e_valid = 0; e_wbase = BASE; e_rbase = BASE;
        end else begin
            int  pick;
            bit  can_grant;
            pick = -1;
            for (int s = 2; s >= 0; s--) begin
                bit used;
                used = (s == m_wr) || (s == m_rd);
                foreach (rq[k]) if (rq[k] == s) used = 1;
                if (!used) pick = s;
            end
            can_grant = req && (m_wr < 0) && (pick >= 0);
            e_grant = 0;
            if (done && m_wr >= 0) begin
                rq.push_back(m_wr);
                m_wr = -1;
            end
            if (rds && rq.size() > 0) begin
                m_rd = rq.pop_front();
                e_valid = 1;
                e_rbase = addr(m_rd);
            end
            if (can_grant) begin
                m_wr = pick;
                e_grant = 1;
                e_wbase = addr(pick);
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        chk("R5 grant", {31'd0, grant}, {31'd0, e_grant});
        chk("R3 wr_base", wbase, e_wbase);
        chk("R9 rd_valid", {31'd0, valid}, {31'd0, e_valid});
        chk("R7 rd_base", rbase, e_rbase);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (3) step();
        // R1
        chk("R1 reset grant", {31'd0, grant}, 32'd0);
        chk("R1 reset valid", {31'd0, valid}, 32'd0);
        chk("R1 reset base", rbase, BASE);
        rst_n = 1'b1;
        step();
        chk("R1 after reset", {31'd0, valid}, 32'd0);

        // R9: start with nothing completed
        rds = 1; step(); rds = 0; step();
        chk("R9 no frame yet", {31'd0, valid}, 32'd0);

        // R6: stray done while nothing is being filled
        done = 1; step(); done = 0;
        rds = 1; step(); rds = 0; step();
        chk("R6 stray done ignored", {31'd0, valid}, 32'd0);

        // First frame into region 0
        req = 1; step(); req = 0;
        chk("R3 first grant", {31'd0, grant}, 32'd1);
        chk("R2 region0 base", wbase, 32'h1000_0000);
        repeat (5) step();
        done = 1; step(); done = 0;
        rds = 1; step(); rds = 0;
        chk("R7 first scan", rbase, 32'h1000_0000);
        chk("R9 valid after frame", {31'd0, valid}, 32'd1);

        // R8: no newer frame, repeat
        repeat (3) step();
        rds = 1; step(); rds = 0;
        chk("R8 repeat frame", rbase, 32'h1000_0000);

        // Regions 1 and 2
        req = 1; step(); req = 0;
        chk("R2 region1 base", wbase, 32'h1024_0000);
        step(); done = 1; step(); done = 0;
        req = 1; step(); req = 0;
        chk("R2 region2 base", wbase, 32'h1048_0000);
        step(); done = 1; step(); done = 0;

        // R4: all regions occupied, writer stalls
        req = 1;
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R4 stalled", {31'd0, grant}, 32'd0);
        end
        rds = 1; step(); rds = 0;
        chk("R7 oldest unread", rbase, 32'h1024_0000);
        chk("R4 no grant on free edge", {31'd0, grant}, 32'd0);
        step();
        chk("R4 released grant", {31'd0, grant}, 32'd1);
        chk("R4 freed region reused", wbase, 32'h1000_0000);
        req = 0;

        // R10: base holds mid-frame
        repeat (4) step();
        chk("R10 base held", rbase, 32'h1024_0000);

        // R11: done and start in same cycle, queue otherwise empty
        rds = 1; step(); rds = 0;
        chk("R7 next unread", rbase, 32'h1048_0000);
        step();
        done = 1; rds = 1; step(); done = 0; rds = 0;
        chk("R11 same-cycle pickup", rbase, 32'h1000_0000);

        // Random traffic against the reference
        for (int i = 0; i < 3000; i++) begin
            req  = 1'($urandom_range(0, 1));
            done = ($urandom_range(0, 9) == 0);
            rds  = ($urandom_range(0, 7) == 0);
            step();
        end
        req = 0; done = 0; rds = 0;
        step();

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R1 got=running exp=finished");
            summary();
            $finish;
        end
    end
endmodule